// File: doc/BRIEF.md
# Dual-Channel Auxiliary PWM Generator

This block drives two pulse-width-modulated outputs from five write-only registers: two period/offset registers, two on-time registers and a mode register. All times are counted in units of two system clocks. In independent mode each output runs on its own period. In offset mode both outputs share the first period register. The second period register then sets the delay from a rising edge on output A to the next rising edge on output B.

On-time writes go into a shadow register. The running channel picks up the new value only when its next period starts, so a pulse already in progress keeps its width. A write to either period register or to the mode register clears both timers and starts fresh cycles on the following clock. Writes to unused addresses are dropped. The outputs are registered and suit an external RC filter used as a coarse DAC.

Top module: `aux_pwm_pair`

## Requirements
- R1: In independent mode (mode bit = 1), output A repeats every 2*(PA+1) clocks and output B every 2*(PB+1) clocks. PA is the value at address 0 and PB is the value at address 1.
- R2: Each output stays high for 2*ON clocks per period, where ON is the value at address 2 (A) or address 3 (B). ON = 0 keeps the output low. ON greater than the channel's period value keeps it high.
- R3: In offset mode (mode bit = 0), both outputs repeat every 2*(PA+1) clocks. Each rising edge of B comes 2*(PB+1) clocks after a rising edge of A. This holds when PB < PA. After a restart, B stays low until its first delayed period start.
- R4: A new on-time value is held back until the next period start of its channel. The pulse in progress when it is written keeps its old width.
- R5: A write to address 0, 1 or 4 clears both timers on the next clock. Output A, if 0 < ON < PA+1, then rises two clocks after the edge that took the write.
- R6: Address 4 is the mode register. Only bit 8 is used (1 = independent, 0 = offset) and all other bits are ignored. Reset clears the bit, which selects offset mode.
- R7: Synchronous reset loads 0xFFFF into both period registers and 0 into both on-time registers, and drives both outputs low.
- R8: Writes to addresses 5 to 7 change no register and do not restart the timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Register address (0 PA, 1 PB, 2 ON A, 3 ON B, 4 mode) |
| wr_data | input | 16 | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The bench goes after on-time values at 0, at exactly one past the period and far above it. A design with an off-by-one compare would leave a one-tick glitch or lose the full-high level. Offset mode is checked at the smallest delay (PB = 0) and the largest valid one (PB = PA-1), and with the mode bit left at its reset value. A wrong preload or a mode that does not reset to offset would show up as a shifted B edge. An on-time write in the middle of a pulse must leave that pulse alone. Writes to the unused addresses are placed so that a decoder that drops the top address bit would visibly shift the phase or change the pulse width.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PER_A = 3'd0,
    ADDR_PER_B = 3'd1,
    ADDR_ON_A  = 3'd2,
    ADDR_ON_B  = 3'd3,
    ADDR_MODE  = 3'd4
  } reg_addr_e;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/aux_pwm_regs.sv
module aux_pwm_regs
  import aux_pwm_pkg::*;
#(
  parameter int W        = 16,
  parameter int MODE_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic [W-1:0]      per_a,
  output logic [W-1:0]      per_b,
  output logic [W-1:0]      on_a,
  output logic [W-1:0]      on_b,
  output logic              indep,
  output logic              restart
);
  logic hit_per_a, hit_per_b, hit_on_a, hit_on_b, hit_mode;

  always_comb begin
    hit_per_a = 1'b0;
    hit_per_b = 1'b0;
    hit_on_a  = 1'b0;
    hit_on_b  = 1'b0;
    hit_mode  = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        ADDR_PER_A: hit_per_a = 1'b1;
        ADDR_PER_B: hit_per_b = 1'b1;
        ADDR_ON_A:  hit_on_a  = 1'b1;
        ADDR_ON_B:  hit_on_b  = 1'b1;
        ADDR_MODE:  hit_mode  = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_a   <= '1;
      per_b   <= '1;
      on_a    <= '0;
      on_b    <= '0;
      indep   <= 1'b0;
      restart <= 1'b0;
    end else begin
      if (hit_per_a) per_a <= wr_data;
      if (hit_per_b) per_b <= wr_data;
      if (hit_on_a)  on_a  <= wr_data;
      if (hit_on_b)  on_b  <= wr_data;
      if (hit_mode)  indep <= wr_data[MODE_BIT];
      restart <= hit_per_a | hit_per_b | hit_mode;
    end
  end

  p_reset_defaults_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (per_a == '1 && per_b == '1 && on_a == '0 && on_b == '0 && !indep));

  p_mode_write_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_MODE) |=> (indep == $past(wr_data[MODE_BIT]) && restart));

  p_period_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == ADDR_PER_A || wr_addr == ADDR_PER_B)) |=> restart);

  p_ignored_addr_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > ADDR_MODE) |=> ($stable(per_a) && $stable(per_b) && $stable(on_a)
                                       && $stable(on_b) && $stable(indep) && !restart));
endmodule

// File: rtl/aux_pwm_prescale.sv
module aux_pwm_prescale (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst || restart) phase <= 1'b0;
    else                phase <= ~phase;
  end

  assign tick = phase;

  p_tick_alternates_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart) |=> !tick);

  p_restart_phase_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
endmodule

// File: rtl/aux_pwm_chan.sv
module aux_pwm_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic         tick,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] init_cnt,
  input  logic         init_quiet,
  input  logic [W-1:0] on_shadow,
  output logic         pwm
);
  logic [W-1:0] cnt;
  logic [W-1:0] on_eff;
  logic         wrap;

  assign wrap = tick && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      on_eff <= '0;
      pwm    <= 1'b0;
    end else begin
      pwm <= (cnt < on_eff);
      if (restart) begin
        cnt    <= init_cnt;
        on_eff <= init_quiet ? '0 : on_shadow;
      end else if (tick) begin
        if (wrap) begin
          cnt    <= '0;
          on_eff <= on_shadow;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (rst)
    (!restart && !tick) |=> $stable(cnt));

  p_zero_duty_r2: assert property (@(posedge clk) disable iff (rst)
    (on_eff == '0) |=> !pwm);

  p_quiet_after_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (restart && init_quiet) |=> ##1 !pwm);

  p_shadow_held_r4: assert property (@(posedge clk) disable iff (rst)
    (!restart && !wrap) |=> $stable(on_eff));

  p_restart_load_r5: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == $past(init_cnt)));
endmodule

// File: rtl/aux_pwm_pair.sv
module aux_pwm_pair
  import aux_pwm_pkg::*;
#(
  parameter int W        = 16,
  parameter int MODE_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              pwm_a,
  output logic              pwm_b
);
  logic [W-1:0] per_a, per_b, on_a, on_b;
  logic         indep, restart, tick;

  logic [W-1:0]      lim_v   [NUM_CH];
  logic [W-1:0]      init_v  [NUM_CH];
  logic [W-1:0]      on_v    [NUM_CH];
  logic              quiet_v [NUM_CH];
  logic [NUM_CH-1:0] pwm_v;

  aux_pwm_regs #(.W(W), .MODE_BIT(MODE_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .per_a(per_a), .per_b(per_b), .on_a(on_a), .on_b(on_b),
    .indep(indep), .restart(restart)
  );

  aux_pwm_prescale u_pre (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  // Channel A always runs on its own period from zero.
  assign lim_v[0]   = per_a;
  assign init_v[0]  = '0;
  assign quiet_v[0] = 1'b0;
  assign on_v[0]    = on_a;

  // Channel B: own period, or A's period preloaded so its first wrap lags by PB+1 ticks.
  assign lim_v[1]   = indep ? per_b : per_a;
  assign init_v[1]  = indep ? '0 : (per_a - per_b);
  assign quiet_v[1] = ~indep;
  assign on_v[1]    = on_b;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    aux_pwm_chan #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .restart(restart), .tick(tick),
      .lim(lim_v[c]), .init_cnt(init_v[c]), .init_quiet(quiet_v[c]),
      .on_shadow(on_v[c]), .pwm(pwm_v[c])
    );
  end

  assign pwm_a = pwm_v[0];
  assign pwm_b = pwm_v[1];

  p_reset_outputs_low_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pwm_a && !pwm_b));
endmodule

// File: tb/aux_pwm_pair_tb.sv
module aux_pwm_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_a, pwm_b;

  aux_pwm_pair u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Edge monitor, sampled away from the active edge.
  int rise_a = 0, rise_b = 0, per_a_m = 0, per_b_m = 0, hi_a = 0, hi_b = 0, off_m = 0;
  int nr_a = 0, nr_b = 0, nf_a = 0;
  logic pa = 1'b0, pb = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      pa = 1'b0; pb = 1'b0;
    end else begin
      if (pwm_a && !pa) begin per_a_m = cyc - rise_a; rise_a = cyc; nr_a++; end
      if (!pwm_a && pa) begin hi_a = cyc - rise_a; nf_a++; end
      if (pwm_b && !pb) begin per_b_m = cyc - rise_b; off_m = cyc - rise_a; rise_b = cyc; nr_b++; end
      if (!pwm_b && pb) hi_b = cyc - rise_b;
      pa = pwm_a; pb = pwm_b;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // 0: never high, 1: always high, 2: pulsing
  function automatic int kind(int on, int lim);
    if (on == 0) return 0;
    if (on >= lim + 1) return 1;
    return 2;
  endfunction

  function automatic int exp_period(int lim); return 2 * (lim + 1); endfunction
  function automatic int exp_high(int on);    return 2 * on;        endfunction

  // md < 0 leaves the mode register untouched
  task automatic run_cfg(int md, int t0, int t1, int c0, int c1);
    bit ind;
    int lb, span, ka, kb;
    ind = (md >= 0) ? md[8] : 1'b0;
    wr(2, c0); wr(3, c1);
    if (md >= 0) wr(4, md);
    wr(1, t1); wr(0, t0);
    lb   = ind ? t1 : t0;
    span = exp_period(t0) + exp_period(t1);
    repeat (3 * span + 8) @(posedge clk);
    nr_a = 0; nr_b = 0;
    repeat (2 * span + 8) @(posedge clk);
    ka = kind(c0, t0);
    kb = kind(c1, lb);
    if (ka == 2) begin
      check(ind ? "R1" : "R3", "A period", per_a_m, exp_period(t0));
      check("R2", "A high time", hi_a, exp_high(c0));
    end else begin
      check("R2", "A edges at 0/100%", nr_a, 0);
      check("R2", "A level at 0/100%", int'(pwm_a), ka);
    end
    if (kb == 2) begin
      check(ind ? "R1" : "R3", "B period", per_b_m, exp_period(lb));
      check("R2", "B high time", hi_b, exp_high(c1));
    end else begin
      check("R2", "B edges at 0/100%", nr_b, 0);
      check("R2", "B level at 0/100%", int'(pwm_b), kb);
    end
    if (!ind && ka == 2 && kb == 2)
      check("R3", "B rise after A rise", off_m, exp_period(t1));
  endtask

  initial begin
    int n0, r0, e0;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R7: outputs low after reset; on-time written alone waits for a 0xFFFF-long period
    check("R7", "A after reset", int'(pwm_a), 0);
    check("R7", "B after reset", int'(pwm_b), 0);
    wr(2, 3);
    repeat (600) @(posedge clk);
    check("R7", "A rises with default period", nr_a, 0);
    check("R7", "B rises with default period", nr_b, 0);

    // R6: mode untouched after reset means offset mode
    run_cfg(-1, 9, 3, 4, 2);
    // R1 independent
    run_cfg(16'h0100, 7, 12, 3, 5);
    // R6 other bits ignored -> offset; R3 minimum delay
    run_cfg(16'hFEFF, 11, 0, 6, 6);
    // R6 all bits set -> independent; R2 0% and exact full-duty boundary
    run_cfg(16'hFFFF, 5, 8, 0, 9);
    // R3 largest valid delay; R2 full-duty on A
    run_cfg(16'h0000, 10, 9, 11, 1);
    // R2 on-time far above period
    run_cfg(16'h0100, 4, 6, 16'hFFFF, 2);

    // R4: on-time write mid-pulse keeps current width
    run_cfg(16'h0100, 20, 20, 5, 5);
    @(posedge clk); n0 = nr_a;
    while (nr_a == n0) @(posedge clk);
    wr(2, 12);
    @(posedge clk); n0 = nf_a;
    while (nf_a == n0) @(posedge clk);
    check("R4", "pulse in progress", hi_a, exp_high(5));
    n0 = nf_a;
    while (nf_a == n0) @(posedge clk);
    check("R4", "next pulse", hi_a, exp_high(12));

    // R5: period write restarts, A rises two clocks later
    run_cfg(16'h0100, 15, 15, 4, 4);
    @(posedge clk); n0 = nf_a;
    while (nf_a == n0) @(posedge clk);
    repeat (3) @(posedge clk);
    wr(0, 15);
    e0 = cyc;
    @(posedge clk); n0 = nr_a;
    while (nr_a == n0) @(posedge clk);
    check("R5", "A rise after restart", rise_a - e0, 2);
    // R5 via mode write
    repeat (5) @(posedge clk);
    wr(4, 16'h0100);
    e0 = cyc;
    @(posedge clk); n0 = nr_a;
    while (nr_a == n0) @(posedge clk);
    check("R5", "A rise after mode write", rise_a - e0, 2);

    // R8: unused addresses are dropped
    @(posedge clk); n0 = nr_a;
    while (nr_a == n0) @(posedge clk);
    r0 = rise_a;
    wr(5, 3); wr(6, 0); wr(7, 1);
    repeat (80) @(posedge clk);
    check("R8", "A phase kept", (rise_a - r0) % 32, 0);
    check("R8", "A period kept", per_a_m, 32);
    check("R8", "A high kept", hi_a, 8);

    // Random configurations in both modes
    for (int i = 0; i < 24; i++) begin
      int ind, t0, t1, c0, c1;
      ind = $urandom % 2;
      t0  = 2 + $urandom % 30;
      t1  = ind ? (1 + $urandom % 30) : ($urandom % t0);
      c0  = $urandom % (t0 + 3);
      c1  = $urandom % ((ind ? t1 : t0) + 3);
      run_cfg(ind ? 16'h0100 : 16'h0000, t0, t1, c0, c1);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule